// File: doc/BRIEF.md
# Speculative Read-Set Conflict Detector

This block follows the memory footprint of one processor while it runs a speculative transaction. It observes the processor's local loads and stores. Loads mark lines as read and stores mark lines as written. Separately, it watches a single snoop port that carries the addresses other processors make globally visible when they commit. When a snooped address falls inside the local read set, the running transaction has consumed stale data. The block then raises a violation, which holds until the surrounding core acknowledges it with an abort and rolls back.

The block finds conflicts only this way. It tracks no line ownership, and it sends no coherence messages of its own. Its only coherence action is a one-cycle invalidate command to the cache data array. It issues this command when a snooped address lands on a line the cache holds and that line is not in the read set. A parameter chooses whether read state is kept once per line or once per 4-byte word. Per-word read state removes false conflicts between neighbouring words of the same line. Commit or abort wipes all read and written marks in a single clock.

Top module: `txn_conflict_detector`

## Requirements
- R1: After synchronous reset, `viol_o` and `inv_o` are low and no transaction is open.
- R2: A `txn_begin` opens a transaction from the next cycle on. A local access that happens outside an open transaction, including one in the same cycle as `txn_begin`, sets no read or written mark. Such an access does mark its line as held by the cache.
- R3: When `PER_WORD=0`, a load inside an open transaction marks its line (address bits [11:4]) as read. A later snoop to any byte of that line drives `viol_o` high on the cycle after the snoop.
- R4: When `PER_WORD=1`, read marks are kept for each 4-byte word, selected by address bits [3:2]. A snoop to another word of a read line gives no violation.
- R5: A load to a line already written in the same transaction sets no read mark, because the transaction's own write supplied the value.
- R6: Once high, `viol_o` stays high until `txn_abort`, and it is low on the cycle after the abort. A `txn_commit` while `viol_o` is high has no effect.
- R7: A commit or abort clears every read and written mark in one cycle, so a snoop on the next cycle causes no violation.
- R8: A snoop to a line the cache holds, with no read-mark hit, produces a one-cycle `inv_o` pulse on the next cycle, with `inv_line_o` equal to the snoop address bits [11:4]. After this pulse the line is no longer held. A snoop to a line that is not held gives no pulse. A local access to the same line in the same cycle as the snoop keeps the line held.
- R9: A snoop that hits the read set produces no `inv_o` pulse.
- R10: A commit in the same cycle as a conflicting snoop takes priority, and no violation is raised.
- R11: A store sets only the written mark, so a snoop to a line that was only stored causes no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Local access present this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Local byte address |
| snp_valid | input | 1 | Committed address from another processor present |
| snp_addr | input | ADDR_W | Snooped committed byte address |
| txn_begin | input | 1 | Open a transaction |
| txn_commit | input | 1 | Transaction committed |
| txn_abort | input | 1 | Abort / violation acknowledge |
| viol_o | output | 1 | Sticky conflict flag requesting rollback |
| inv_o | output | 1 | One-cycle invalidate command |
| inv_line_o | output | ADDR_W-4 | Line index to invalidate |

## Verification
A read mark that is lost or set by mistake shows at the ports one cycle after the next snoop to that line. It appears as a missing or spurious `viol_o`, together with the opposite error on `inv_o`. A wrong held-line bit shows as a missing or extra invalidate pulse on the first snoop to that line. Errors in the state machine appear as `viol_o` dropping without an abort, or staying high after one. The bench drives both read-mark granularities with the same traffic and compares every output on every cycle.

// File: rtl/txn_det_pkg.sv
package txn_det_pkg;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_RUN  = 2'd1,
        TS_VIOL = 2'd2
    } txn_state_e;

    typedef struct packed {
        logic open_req;
        logic done_req;
        logic kill_req;
    } txn_ctl_t;

    // Transaction state step: abort first, then commit, then begin, then conflict.
    function automatic txn_state_e txn_next(input txn_state_e cur, input txn_ctl_t ctl,
                                            input logic hit);
        txn_state_e nxt;
        nxt = cur;
        if (ctl.kill_req)
            nxt = TS_IDLE;
        else if (ctl.done_req && cur == TS_RUN)
            nxt = TS_IDLE;
        else if (ctl.open_req && cur == TS_IDLE)
            nxt = TS_RUN;
        else if (hit && cur == TS_RUN)
            nxt = TS_VIOL;
        return nxt;
    endfunction

    function automatic logic txn_wipe(input txn_state_e cur, input txn_ctl_t ctl);
        return ctl.kill_req || (ctl.done_req && cur == TS_RUN);
    endfunction

endpackage

// File: rtl/txn_ctrl.sv
module txn_ctrl
    import txn_det_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  txn_ctl_t ctl,
    input  logic     snp_hit,
    output logic     track_en,
    output logic     wipe,
    output logic     viol
);
    txn_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= TS_IDLE;
        else
            state_q <= txn_next(state_q, ctl, snp_hit);
    end

    assign track_en = (state_q == TS_RUN);
    assign wipe     = txn_wipe(state_q, ctl);
    assign viol     = (state_q == TS_VIOL);

endmodule

// File: rtl/txn_rd_track.sv
module txn_rd_track #(
    parameter int LW       = 8,
    parameter int WW       = 2,
    parameter bit PER_WORD = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wipe,
    input  logic          track_en,
    input  logic          acc_valid,
    input  logic          acc_store,
    input  logic [LW-1:0] acc_line,
    input  logic [WW-1:0] acc_word,
    input  logic          snp_valid,
    input  logic [LW-1:0] snp_line,
    input  logic [WW-1:0] snp_word,
    output logic          snp_hit,
    output logic          inv_now
);
    localparam int NLINES = 1 << LW;
    localparam int RIW    = PER_WORD ? (LW + WW) : LW;
    localparam int NRD    = 1 << RIW;

    logic [NRD-1:0]    rd_q;
    logic [NLINES-1:0] wr_q;
    logic [NLINES-1:0] held_q;
    logic [RIW-1:0]    acc_ridx;
    logic [RIW-1:0]    snp_ridx;

    generate
        if (PER_WORD) begin : g_word
            assign acc_ridx = {acc_line, acc_word};
            assign snp_ridx = {snp_line, snp_word};
        end else begin : g_line
            logic unused_words;
            assign unused_words = ^{acc_word, snp_word};
            assign acc_ridx = acc_line;
            assign snp_ridx = snp_line;
        end
    endgenerate

    assign snp_hit = snp_valid && rd_q[snp_ridx];
    assign inv_now = snp_valid && held_q[snp_line] && !rd_q[snp_ridx];

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            rd_q <= '0;
            wr_q <= '0;
        end else if (track_en && acc_valid) begin
            if (acc_store)
                wr_q[acc_line] <= 1'b1;
            else if (!wr_q[acc_line])
                rd_q[acc_ridx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else begin
            if (inv_now)
                held_q[snp_line] <= 1'b0;
            if (acc_valid)
                held_q[acc_line] <= 1'b1;
        end
    end

endmodule

// File: rtl/txn_conflict_detector.sv
module txn_conflict_detector
    import txn_det_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LINE_OFF_W = 4,
    parameter int WORD_OFF_W = 2,
    parameter bit PER_WORD   = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         acc_valid,
    input  logic                         acc_store,
    input  logic [ADDR_W-1:0]            acc_addr,
    input  logic                         snp_valid,
    input  logic [ADDR_W-1:0]            snp_addr,
    input  logic                         txn_begin,
    input  logic                         txn_commit,
    input  logic                         txn_abort,
    output logic                         viol_o,
    output logic                         inv_o,
    output logic [ADDR_W-LINE_OFF_W-1:0] inv_line_o
);
    localparam int LW = ADDR_W - LINE_OFF_W;
    localparam int WW = LINE_OFF_W - WORD_OFF_W;

    txn_ctl_t ctl;
    logic     track_en, wipe, snp_hit, inv_now;
    logic     unused_lsb;

    assign ctl = '{open_req: txn_begin, done_req: txn_commit, kill_req: txn_abort};
    assign unused_lsb = ^{acc_addr[WORD_OFF_W-1:0], snp_addr[WORD_OFF_W-1:0]};

    txn_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .snp_hit (snp_hit),
        .track_en(track_en),
        .wipe    (wipe),
        .viol    (viol_o)
    );

    txn_rd_track #(.LW(LW), .WW(WW), .PER_WORD(PER_WORD)) u_track (
        .clk      (clk),
        .rst      (rst),
        .wipe     (wipe),
        .track_en (track_en),
        .acc_valid(acc_valid),
        .acc_store(acc_store),
        .acc_line (acc_addr[ADDR_W-1:LINE_OFF_W]),
        .acc_word (acc_addr[LINE_OFF_W-1:WORD_OFF_W]),
        .snp_valid(snp_valid),
        .snp_line (snp_addr[ADDR_W-1:LINE_OFF_W]),
        .snp_word (snp_addr[LINE_OFF_W-1:WORD_OFF_W]),
        .snp_hit  (snp_hit),
        .inv_now  (inv_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_o      <= 1'b0;
            inv_line_o <= '0;
        end else begin
            inv_o      <= inv_now;
            inv_line_o <= snp_addr[ADDR_W-1:LINE_OFF_W];
        end
    end

endmodule

// File: rtl/txn_conflict_chk.sv
module txn_conflict_chk (
    input logic clk,
    input logic rst,
    input logic snp_valid,
    input logic txn_commit,
    input logic txn_abort,
    input logic viol_o,
    input logic inv_o
);
    // R6
    viol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        viol_o && !txn_abort |=> viol_o);

    // R6
    viol_clear_chk: assert property (@(posedge clk) disable iff (rst)
        txn_abort |=> !viol_o);

    // R3
    viol_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(viol_o) |-> $past(snp_valid) && !$past(txn_abort) && !$past(txn_commit));

    // R8
    inv_cause_chk: assert property (@(posedge clk) disable iff (rst)
        inv_o |-> $past(snp_valid));

    // R9
    inv_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(viol_o) |-> !inv_o);

endmodule

bind txn_conflict_detector txn_conflict_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .snp_valid (snp_valid),
    .txn_commit(txn_commit),
    .txn_abort (txn_abort),
    .viol_o    (viol_o),
    .inv_o     (inv_o)
);

// File: tb/txn_conflict_detector_bench.sv
module txn_conflict_detector_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_store, snp_valid;
    logic        txn_begin, txn_commit, txn_abort;
    logic [11:0] acc_addr, snp_addr;
    logic        viol_l, viol_w, inv_l, inv_w;
    logic [7:0]  line_l, line_w;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit rd0 [256];
    bit rd1 [1024];
    bit wr  [2][256];
    bit held[2][256];
    int st  [2];
    bit e_viol[2];
    bit e_inv [2];
    logic [7:0] e_line;

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_conflict_detector #(.PER_WORD(1'b0)) u_txn_conflict_detector (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_addr(acc_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .txn_begin(txn_begin), .txn_commit(txn_commit), .txn_abort(txn_abort),
        .viol_o(viol_l), .inv_o(inv_l), .inv_line_o(line_l));

    txn_conflict_detector #(.PER_WORD(1'b1)) u_txn_conflict_detector_w (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_addr(acc_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .txn_begin(txn_begin), .txn_commit(txn_commit), .txn_abort(txn_abort),
        .viol_o(viol_w), .inv_o(inv_w), .inv_line_o(line_w));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        foreach (rd0[i]) rd0[i] = 0;
        foreach (rd1[i]) rd1[i] = 0;
        for (int c = 0; c < 2; c++) begin
            st[c] = 0;
            for (int i = 0; i < 256; i++) begin
                wr[c][i] = 0;
                held[c][i] = 0;
            end
        end
    endtask

    task automatic step(input logic b, input logic cm, input logic ab,
                        input logic av, input logic ast, input logic [11:0] aa,
                        input logic sv, input logic [11:0] sa, input string tag);
        int sl, sw, al, aw, pre;
        bit hit, clr;
        @(negedge clk);
        txn_begin = b; txn_commit = cm; txn_abort = ab;
        acc_valid = av; acc_store = ast; acc_addr = aa;
        snp_valid = sv; snp_addr = sa;
        sl = int'(sa[11:4]); sw = int'(sa[3:2]);
        al = int'(aa[11:4]); aw = int'(aa[3:2]);
        e_line = sa[11:4];
        for (int c = 0; c < 2; c++) begin
            hit = sv && ((c == 0) ? rd0[sl] : rd1[sl*4 + sw]);
            e_inv[c] = sv && held[c][sl] && !hit;
            pre = st[c];
            clr = ab || (cm && pre == 1);
            if (ab) st[c] = 0;
            else if (cm && pre == 1) st[c] = 0;
            else if (pre == 0 && b) st[c] = 1;
            else if (pre == 1 && hit) st[c] = 2;
            if (clr) begin
                for (int i = 0; i < 256; i++) wr[c][i] = 0;
                if (c == 0) foreach (rd0[i]) rd0[i] = 0;
                else foreach (rd1[i]) rd1[i] = 0;
            end else if (pre == 1 && av) begin
                if (ast) wr[c][al] = 1;
                else if (!wr[c][al]) begin
                    if (c == 0) rd0[al] = 1;
                    else rd1[al*4 + aw] = 1;
                end
            end
            if (e_inv[c]) held[c][sl] = 0;
            if (av) held[c][al] = 1;
            e_viol[c] = (st[c] == 2);
        end
        @(posedge clk);
        #1;
        check({tag, " viol line-mode"}, viol_l, e_viol[0]);
        check({tag, " viol word-mode"}, viol_w, e_viol[1]);
        check({tag, " inv line-mode"},  inv_l,  e_inv[0]);
        check({tag, " inv word-mode"},  inv_w,  e_inv[1]);
        if (e_inv[0]) check({tag, " inv_line line-mode"}, line_l, e_line);
        if (e_inv[1]) check({tag, " inv_line word-mode"}, line_w, e_line);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 12'h0, 0, 12'h0, tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        logic b, cm, ab, av, ast, sv;
        logic [11:0] aa, sa;
        seed = 32'h5eed;
        void'($urandom(seed));
        rst = 1; txn_begin = 0; txn_commit = 0; txn_abort = 0;
        acc_valid = 0; acc_store = 0; acc_addr = 0; snp_valid = 0; snp_addr = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1;
        check("R1 viol after reset", viol_l, 0);
        check("R1 inv after reset", inv_w, 0);

        // R2: loads outside and at begin are untracked, but fill lines
        step(0, 0, 0, 1, 0, 12'h020, 0, 12'h0, "R2 load outside txn");
        step(1, 0, 0, 1, 0, 12'h030, 0, 12'h0, "R2 load with begin");
        step(0, 0, 0, 0, 0, 12'h0, 1, 12'h024, "R2 R8 snoop untracked line2");
        step(0, 0, 0, 0, 0, 12'h0, 1, 12'h030, "R2 R8 snoop untracked line3");
        step(0, 0, 0, 0, 0, 12'h0, 1, 12'h0F0, "R8 snoop line not held");
        // R3/R4: line vs word granularity
        step(0, 0, 0, 1, 0, 12'h010, 0, 12'h0, "R3 load line1 word0");
        step(0, 0, 0, 0, 0, 12'h0, 1, 12'h01C, "R3 R4 snoop line1 word3");
        step(0, 1, 0, 0, 0, 12'h0, 0, 12'h0, "R6 commit while violated");
        idle("R6 viol held");
        step(0, 0, 1, 0, 0, 12'h0, 0, 12'h0, "R6 abort clears");
        // R5/R11: store then load same line
        step(1, 0, 0, 0, 0, 12'h0, 0, 12'h0, "R5 begin");
        step(0, 0, 0, 1, 1, 12'h040, 0, 12'h0, "R11 store line4");
        step(0, 0, 0, 1, 0, 12'h040, 0, 12'h0, "R5 load after own store");
        step(0, 0, 0, 0, 0, 12'h0, 1, 12'h048, "R5 R11 snoop written line");
        // R10: commit beats conflicting snoop
        step(0, 0, 0, 1, 0, 12'h050, 0, 12'h0, "R10 load line5");
        step(0, 1, 0, 0, 0, 12'h0, 1, 12'h050, "R10 R9 commit with snoop");
        idle("R10 no viol after");
        // R7: bits wiped by commit
        step(1, 0, 0, 0, 0, 12'h0, 0, 12'h0, "R7 begin");
        step(0, 0, 0, 1, 0, 12'h060, 0, 12'h0, "R7 load line6");
        step(0, 1, 0, 0, 0, 12'h0, 0, 12'h0, "R7 commit");
        step(0, 0, 0, 0, 0, 12'h0, 1, 12'h060, "R7 snoop after commit");
        // R9: conflicting snoop gives no invalidate
        step(1, 0, 0, 0, 0, 12'h0, 0, 12'h0, "R9 begin");
        step(0, 0, 0, 1, 0, 12'h070, 0, 12'h0, "R9 load line7");
        step(0, 0, 0, 0, 0, 12'h0, 1, 12'h070, "R9 snoop read line");
        // R8: same-cycle access keeps line held
        step(0, 0, 1, 1, 0, 12'h080, 1, 12'h080, "R8 access and snoop same line");
        step(0, 0, 0, 0, 0, 12'h0, 1, 12'h084, "R8 line still held");
        idle("R8 idle");

        for (int n = 0; n < 4000; n++) begin
            b   = ($urandom % 8) == 0;
            cm  = ($urandom % 24) == 0;
            ab  = ($urandom % 24) == 0;
            av  = ($urandom % 2) == 0;
            ast = ($urandom % 3) == 0;
            sv  = ($urandom % 3) == 0;
            aa  = {4'h0, 4'($urandom % 8), 4'($urandom)};
            sa  = {4'h0, 4'($urandom % 8), 4'($urandom)};
            step(b, cm, ab, av, ast, aa, sv, sa, "R3 R4 R5 R6 R8 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule